// File: doc/BRIEF.md
# Maskable Interrupt Flag Controller

This block collects edge events from a set of asynchronous status sources into three banks of eight sticky flags. Each bank has a mask register and an edge-mode register. A source that is not masked raises its flag when it sees the edge its mode selects: a rising edge only, or either edge. While any flag is raised, the block enables the low drive of an active-low open-drain interrupt pin. When no flag is raised, the pin is released to its external pull-up.

A host reads and writes the nine registers through a simple single-cycle register port. Reading a flag bank returns its contents and clears them in the same cycle. The interrupt is released once no flag remains. The physical bus protocol sits outside this block and drives the register port.

Register addresses: flag banks 0..2 at addresses 0, 1, 2 (read-only, clear on read). Mask banks at 3, 4, 5 (bit value 1 = masked). Edge-mode banks at 6, 7, 8 (bit value 0 = rising only, 1 = both edges). Event input bit `8*g+i` belongs to bit `i` of bank `g`.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset every mask bit reads 1, every edge-mode bit reads 0, every flag reads 0, and `irq_oe` is 0.
- R2: An unmasked source in rising-only mode (mode bit 0) sets its flag on a 0-to-1 change of its event input, and not on a 1-to-0 change. The flag is set at the third rising clock edge after the input changes.
- R3: An unmasked source in both-edge mode (mode bit 1) sets its flag on a 0-to-1 change and also on a 1-to-0 change.
- R4: A masked source (mask bit 1) never sets its flag. Clearing the mask afterwards does not create a flag for an edge that happened while the source was masked.
- R5: `irq_oe` is 1 in the cycle after any flag bit is 1, and 0 in the cycle after all flag bits are 0.
- R6: A read (`reg_rd`=1) of a flag address returns that bank's flags on `reg_rdata` after the clock edge and clears them at the same edge.
- R7: If a source's edge sets its flag in the same cycle as a clearing read of its bank, the flag stays 1 after the read.
- R8: Reads of addresses 9..15 return 0. Writes to flag addresses 0..2 have no effect on any register.
- R9: A write (`reg_wr`=1) to addresses 3..8 replaces the addressed mask or edge-mode bank, and a later read returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 24 | Asynchronous event sources, bank-major |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, updated at the edge that takes a read |
| irq_oe | output | 1 | Enables the low drive of the open-drain interrupt pin |

## Verification
The checker assumes that the host never raises `reg_rd` and `reg_wr` together. It also assumes that event inputs are low when reset is released, so the synchronizer's reset value does not register a false edge. The stimulus keeps read and write strobes exclusive, holds every event input at 0 through reset, and leaves five clock cycles after each change of the event inputs, so the bench model can count whole edges. Random operations mix event toggles, writes to any address and reads of any address. A directed step places a rising edge exactly on the cycle of the clearing read.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;

    typedef enum logic [1:0] {
        KIND_FLAG = 2'd0,
        KIND_MASK = 2'd1,
        KIND_MODE = 2'd2,
        KIND_NONE = 2'd3
    } reg_kind_e;

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int W      = 24,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] stage [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
            prev_q <= '0;
        end else begin
            stage[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
            prev_q <= stage[STAGES-1];
        end
    end

    assign rise = stage[STAGES-1] & ~prev_q;
    assign fall = ~stage[STAGES-1] & prev_q;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    input  logic         wr_mask,
    input  logic         wr_mode,
    input  logic [W-1:0] wdata,
    input  logic         rd_clr,
    output logic [W-1:0] flag,
    output logic [W-1:0] mask,
    output logic [W-1:0] mode,
    output logic [W-1:0] set
);
    // mode bit 1 adds falling edges; mask bit 1 blocks the source
    assign set = (rise | (fall & mode)) & ~mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= '0;
            mask <= '1;
            mode <= '0;
        end else begin
            flag <= (rd_clr ? '0 : flag) | set;
            if (wr_mask) mask <= wdata;
            if (wr_mode) mode <= wdata;
        end
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_pkg::*;
#(
    parameter int N_GROUPS    = 3,
    parameter int GROUP_W     = 8,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_GROUPS*GROUP_W-1:0]   evt_in,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [GROUP_W-1:0]            reg_wdata,
    output logic [GROUP_W-1:0]            reg_rdata,
    output logic                          irq_oe
);
    localparam int TOTAL     = N_GROUPS * GROUP_W;
    localparam int MASK_BASE = N_GROUPS;
    localparam int MODE_BASE = 2 * N_GROUPS;

    logic [TOTAL-1:0] rise_vec, fall_vec, flag_vec, mask_vec, mode_vec, set_vec;
    reg_kind_e        sel_kind;
    int               sel_grp;
    logic [GROUP_W-1:0] rd_mux;
    irq_state_e       state_q, state_d;
    logic             any_flag;

    irq_edge_det #(.W(TOTAL), .STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (evt_in),
        .rise     (rise_vec),
        .fall     (fall_vec)
    );

    // address decode
    always_comb begin
        sel_kind = KIND_NONE;
        sel_grp  = 0;
        for (int g = 0; g < N_GROUPS; g++) begin
            if (int'(reg_addr) == g) begin
                sel_kind = KIND_FLAG; sel_grp = g;
            end
            if (int'(reg_addr) == g + MASK_BASE) begin
                sel_kind = KIND_MASK; sel_grp = g;
            end
            if (int'(reg_addr) == g + MODE_BASE) begin
                sel_kind = KIND_MODE; sel_grp = g;
            end
        end
    end

    for (genvar gi = 0; gi < N_GROUPS; gi++) begin : g_bank
        logic hit;
        assign hit = (sel_grp == gi);
        irq_flag_bank #(.W(GROUP_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise    (rise_vec[gi*GROUP_W +: GROUP_W]),
            .fall    (fall_vec[gi*GROUP_W +: GROUP_W]),
            .wr_mask (reg_wr && hit && sel_kind == KIND_MASK),
            .wr_mode (reg_wr && hit && sel_kind == KIND_MODE),
            .wdata   (reg_wdata),
            .rd_clr  (reg_rd && hit && sel_kind == KIND_FLAG),
            .flag    (flag_vec[gi*GROUP_W +: GROUP_W]),
            .mask    (mask_vec[gi*GROUP_W +: GROUP_W]),
            .mode    (mode_vec[gi*GROUP_W +: GROUP_W]),
            .set     (set_vec[gi*GROUP_W +: GROUP_W])
        );
    end

    always_comb begin
        unique case (sel_kind)
            KIND_FLAG: rd_mux = flag_vec[sel_grp*GROUP_W +: GROUP_W];
            KIND_MASK: rd_mux = mask_vec[sel_grp*GROUP_W +: GROUP_W];
            KIND_MODE: rd_mux = mode_vec[sel_grp*GROUP_W +: GROUP_W];
            KIND_NONE: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    // interrupt pin state machine
    assign any_flag = |flag_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (any_flag)  state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!any_flag) state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            IRQ_IDLE:   irq_oe = 1'b0;
            IRQ_ACTIVE: irq_oe = 1'b1;
        endcase
    end
endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk #(
    parameter int N_GROUPS = 3,
    parameter int GROUP_W  = 8,
    parameter int ADDR_W   = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_rd,
    input logic [ADDR_W-1:0]           reg_addr,
    input logic [GROUP_W-1:0]          reg_rdata,
    input logic                        irq_oe,
    input logic [N_GROUPS*GROUP_W-1:0] flag_vec,
    input logic [N_GROUPS*GROUP_W-1:0] mask_vec,
    input logic [N_GROUPS*GROUP_W-1:0] set_vec
);
    localparam int LAST_ADDR = 3 * N_GROUPS - 1;

    AST_IRQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_vec) |=> irq_oe); // R5
    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !(|flag_vec) |=> !irq_oe); // R5
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_vec & ~$past(flag_vec) & $past(mask_vec)) == '0); // R4
    AST_SET_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_vec & ~$past(flag_vec) & ~$past(set_vec)) == '0); // R2
    AST_UNLISTED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && int'(reg_addr) > LAST_ADDR) |=> reg_rdata == '0); // R8

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && int'(reg_addr) == g) |=>
            (flag_vec[g*GROUP_W +: GROUP_W] & ~$past(set_vec[g*GROUP_W +: GROUP_W])) == '0); // R6
        AST_COLLIDE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && int'(reg_addr) == g) |=>
            (flag_vec[g*GROUP_W +: GROUP_W] & $past(set_vec[g*GROUP_W +: GROUP_W]))
                == $past(set_vec[g*GROUP_W +: GROUP_W])); // R7
    end
endmodule

bind irq_flag_ctrl irq_flag_chk #(
    .N_GROUPS (N_GROUPS),
    .GROUP_W  (GROUP_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .irq_oe    (irq_oe),
    .flag_vec  (flag_vec),
    .mask_vec  (mask_vec),
    .set_vec   (set_vec)
);

// File: tb/sim_irq_flag_ctrl.sv
module sim_irq_flag_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] evt_in = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [23:0] ev = '0;
    logic [23:0] exp_flag = '0;
    logic [23:0] exp_mask = '1;
    logic [23:0] exp_mode = '0;

    always #10ns clk = ~clk;

    irq_flag_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_oe(irq_oe)
    );

    function automatic logic [23:0] edge_hits(logic [23:0] old_v, logic [23:0] new_v,
                                              logic [23:0] mode);
        return (new_v & ~old_v) | (old_v & ~new_v & mode);
    endfunction

    function automatic logic [7:0] exp_read(int a);
        if (a < 3)      return exp_flag[a*8 +: 8];
        else if (a < 6) return exp_mask[(a-3)*8 +: 8];
        else if (a < 9) return exp_mode[(a-6)*8 +: 8];
        else            return 8'h00;
    endfunction

    function automatic string read_tag(int a);
        if (a < 3)      return "R6";
        else if (a < 9) return "R9";
        else            return "R8";
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(int a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        tick();
        reg_wr = 1'b0;
        if (a >= 3 && a < 6) exp_mask[(a-3)*8 +: 8] = d;
        else if (a >= 6 && a < 9) exp_mode[(a-6)*8 +: 8] = d;
    endtask

    task automatic do_read(int a, string req);
        logic [7:0] e;
        e = exp_read(a);
        reg_rd = 1'b1; reg_addr = 4'(a);
        tick();
        reg_rd = 1'b0;
        check(req, reg_rdata, e);
        if (a < 3) exp_flag[a*8 +: 8] = 8'h00;
        tick();
        check("R5", {7'd0, irq_oe}, {7'd0, |exp_flag});
    endtask

    task automatic toggle(logic [23:0] bits);
        logic [23:0] nv;
        nv = ev ^ bits;
        exp_flag = exp_flag | (edge_hits(ev, nv, exp_mode) & ~exp_mask);
        ev = nv;
        evt_in = ev;
        repeat (5) tick();
        check("R5", {7'd0, irq_oe}, {7'd0, |exp_flag});
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1", {7'd0, irq_oe}, 8'h00);
        for (int a = 0; a < 9; a++) do_read(a, "R1");
        do_read(9, "R8");
        do_read(15, "R8");

        // R4 masked sources stay quiet, unmasking adds nothing
        toggle(24'hFF_FFFF);
        do_read(0, "R4");
        do_read(2, "R4");
        do_write(3, 8'h00);
        repeat (3) tick();
        do_read(0, "R4");

        // R2 rising only: falling edges ignored, rising edge sets
        toggle(24'hFF_FFFF);
        do_read(0, "R2");
        toggle(24'h00_0001);
        check("R2", {7'd0, irq_oe}, 8'h01);
        do_read(0, "R2");
        do_read(0, "R6");

        // R3 both-edge mode on bit 1
        do_write(6, 8'h02);
        toggle(24'h00_0002);
        do_read(0, "R3");
        toggle(24'h00_0002);
        do_read(0, "R3");

        // R7 edge coinciding with clearing read
        toggle(24'h00_0001);
        toggle(24'h00_0001);
        toggle(24'h00_0001);
        ev = ev ^ 24'h00_0001;
        evt_in = ev;
        tick();
        tick();
        reg_rd = 1'b1; reg_addr = 4'd0;
        tick();
        reg_rd = 1'b0;
        check("R7", reg_rdata, 8'h01);
        tick();
        check("R7", {7'd0, irq_oe}, 8'h01);
        do_read(0, "R7");
        do_read(0, "R7");

        // R8 writes to flag addresses ignored
        toggle(24'h00_0001);
        do_write(0, 8'h00);
        do_write(1, 8'hFF);
        do_read(1, "R8");
        do_read(0, "R8");

        // random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom % 4);
            if (op == 0 || op == 1) toggle(24'($urandom) & 24'($urandom));
            else if (op == 2)       do_write(int'($urandom % 16), 8'($urandom));
            else begin
                int a;
                a = int'($urandom % 16);
                do_read(a, read_tag(a));
            end
        end
        for (int a = 0; a < 3; a++) do_read(a, "R6");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule